// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Read Responder

This block stands in for a small serial EEPROM behind one 32-bit control/status register. Software has no SPI master to drive. Instead it toggles a serial-clock bit and a data-in bit in the register, one write at a time, and reads the data-out bit back from the same register. The block advances its internal shift sequence only when a register write raises the serial-clock bit from 0 to 1.

Each command starts with an 8-bit opcode, sent most significant bit first. Opcode 0x03 reads memory. It takes an 8-bit word address, sent MSB first, and then presents the 16 bits of that word one per rising clock edge, least significant bit first. Opcode 0x05 reads the status byte, which is 0x00 (ready, not write-protected), over 8 rising edges. When a command completes, the block is ready for the next one. Any other opcode raises a sticky error output and returns the sequencer to idle.

The memory is 256 words of 16 bits and is read-only. Word `a` holds `{a, a ^ 0xA5}`, except word 0x3F, which holds whatever value makes the sum of words 0x00..0x3F equal 0xBABA modulo 2^16. The register also carries an access-request bit and an access-grant bit, plus a read-only memory-type field that reads 1.

Top module: `eeprom_bitbang_resp`

## Requirements
- R1: After reset, `rd_data` equals 0x0000_0100. The type field in bits [9:8] reads 1 and every other bit reads 0. `err` is low.
- R2: A write takes effect only when `wr_en` is high and `wr_be` is 4'hF. A write with any other byte-enable value leaves `rd_data`, `err` and the sequence position unchanged.
- R3: On every full write, the grant bit (bit 4) takes the value written to the request bit (bit 3).
- R4: A serial step happens only on a full write that takes the clock bit (bit 0) from 0 to 1. Writes that keep the clock bit at 1, or that clear it, advance nothing and leave the data-out bit (bit 2) unchanged.
- R5: The first 8 steps shift the data-in bit (bit 1) into the opcode, MSB first. After opcode 0x03, the next 8 steps shift in the word address, MSB first.
- R6: After the address of a read, step i (i = 0..15) puts bit i of the addressed word on the data-out bit. The value is visible in `rd_data` in the cycle after the write.
- R7: After opcode 0x05, each of the next 8 steps puts 0 on the data-out bit. The sequencer is then idle.
- R8: After 16 read data bits or 8 status bits, all counters clear, so a new command can follow at once with no extra steps.
- R9: A complete opcode other than 0x03 or 0x05 sets `err`. `err` stays high until reset, and the sequencer returns to idle so the next 8 steps form a new opcode.
- R10: Word a (a ≠ 0x3F) reads `{a[7:0], a[7:0] ^ 8'hA5}`. The 16-bit sum of words 0x00..0x3F is 0xBABA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables; only 4'hF is accepted |
| wr_data | input | 32 | Write data: bit0 clock, bit1 data-in, bit3 request |
| rd_data | output | 32 | Register value: bit0 clock, bit1 data-in, bit2 data-out, bit3 request, bit4 grant, [9:8] type |
| err | output | 1 | Sticky flag for an unknown opcode |

## Verification
Internal state shows at the ports in only two ways: the data-out bit one cycle after a rising-clock write, and `err`. A miscounted opcode, address or data counter is therefore caught by reading every word through the register, because the first misplaced bit shows up in the word that follows. A counter that fails to clear shows up as corruption in the next command, so commands are sent back to back with no idle steps between them. Redundant clock writes are inserted partway through a read to expose a sequencer that steps on level rather than on edge.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  localparam int OP_W    = 8;
  localparam int ADR_W   = 8;
  localparam int DAT_W   = 16;
  localparam int STAT_W  = 8;
  localparam int TYPE_W  = 2;
  localparam int CHK_CNT = 64;

  localparam logic [OP_W-1:0]   OP_READ     = 8'h03;
  localparam logic [OP_W-1:0]   OP_STAT     = 8'h05;
  localparam logic [STAT_W-1:0] STATUS_BYTE = 8'h00;
  localparam logic [TYPE_W-1:0] MEM_TYPE    = 2'd1;
  localparam logic [DAT_W-1:0]  CHK_TARGET  = 16'hBABA;

  localparam int B_SCLK   = 0;
  localparam int B_SDI    = 1;
  localparam int B_SDO    = 2;
  localparam int B_REQ    = 3;
  localparam int B_GNT    = 4;
  localparam int TYPE_LSB = 8;

  function automatic logic [DAT_W-1:0] base_word(input logic [ADR_W-1:0] a);
    return {a, a ^ 8'hA5};
  endfunction

  function automatic logic [DAT_W-1:0] fix_word();
    logic [DAT_W-1:0] s;
    s = '0;
    for (int i = 0; i < CHK_CNT - 1; i++) s = s + base_word(ADR_W'(i));
    return CHK_TARGET - s;
  endfunction

  localparam logic [DAT_W-1:0] FIX_WORD = fix_word();

  function automatic logic [DAT_W-1:0] rom_word(input logic [ADR_W-1:0] a);
    return (a == ADR_W'(CHK_CNT - 1)) ? FIX_WORD : base_word(a);
  endfunction
endpackage

// File: rtl/eeb_ctrl_reg.sv
module eeb_ctrl_reg
  import eeb_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int BE_W  = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic             sclk,
  output logic             sdi,
  output logic             req,
  output logic             gnt,
  output logic             step,
  output logic             step_din,
  output logic             wr_full
);
  logic sclk_q, sdi_q, req_q, gnt_q;
  logic sclk_n, sdi_n, req_n, gnt_n;

  assign wr_full  = wr_en && (&wr_be);
  assign step     = wr_full && !sclk_q && wr_data[B_SCLK];
  assign step_din = wr_data[B_SDI];

  always_comb begin
    sclk_n = sclk_q;
    sdi_n  = sdi_q;
    req_n  = req_q;
    gnt_n  = gnt_q;
    if (wr_full) begin
      sclk_n = wr_data[B_SCLK];
      sdi_n  = wr_data[B_SDI];
      req_n  = wr_data[B_REQ];
      gnt_n  = wr_data[B_REQ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sdi_q  <= 1'b0;
      req_q  <= 1'b0;
      gnt_q  <= 1'b0;
    end else if (wr_full) begin
      sclk_q <= sclk_n;
      sdi_q  <= sdi_n;
      req_q  <= req_n;
      gnt_q  <= gnt_n;
    end
  end

  assign sclk = sclk_q;
  assign sdi  = sdi_q;
  assign req  = req_q;
  assign gnt  = gnt_q;
endmodule

// File: rtl/eeb_rom.sv
module eeb_rom
  import eeb_pkg::*;
#(
  parameter int AW = ADR_W,
  parameter int DW = DAT_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  always_comb word = DW'(rom_word(ADR_W'(addr)));
endmodule

// File: rtl/eeb_seq.sv
module eeb_seq
  import eeb_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = ADR_W,
  parameter int DW = DAT_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          din,
  input  logic [DW-1:0] rom_data,
  output logic [AW-1:0] rom_addr,
  output logic          sdo,
  output logic          err
);
  localparam int OCW = $clog2(OW + 1);
  localparam int ACW = $clog2(AW + 1);
  localparam int DCW = $clog2(DW + 1);
  localparam int DIX = $clog2(DW);
  localparam int SIX = $clog2(SW);
  localparam logic [OCW-1:0] OC_FULL = OCW'(OW);
  localparam logic [OCW-1:0] OC_LAST = OCW'(OW - 1);
  localparam logic [ACW-1:0] AC_FULL = ACW'(AW);
  localparam logic [DCW-1:0] DC_LAST = DCW'(DW - 1);
  localparam logic [DCW-1:0] SC_LAST = DCW'(SW - 1);

  logic [OW-1:0]  op_q, op_n;
  logic [OCW-1:0] oc_q, oc_n;
  logic [AW-1:0]  adr_q, adr_n;
  logic [ACW-1:0] ac_q, ac_n;
  logic [DCW-1:0] dc_q, dc_n;
  logic           sdo_q, sdo_n;
  logic           err_q, err_n;
  logic           clr;
  logic [OW-1:0]  op_shift;

  assign op_shift = {op_q[OW-2:0], din};

  always_comb begin
    op_n  = op_q;
    oc_n  = oc_q;
    adr_n = adr_q;
    ac_n  = ac_q;
    dc_n  = dc_q;
    sdo_n = sdo_q;
    err_n = err_q;
    clr   = 1'b0;
    if (step) begin
      if (oc_q != OC_FULL) begin
        op_n = op_shift;
        oc_n = oc_q + 1'b1;
        if (oc_q == OC_LAST && op_shift != OW'(OP_READ) && op_shift != OW'(OP_STAT)) begin
          err_n = 1'b1;
          clr   = 1'b1;
        end
      end else if (op_q == OW'(OP_READ)) begin
        if (ac_q != AC_FULL) begin
          adr_n = {adr_q[AW-2:0], din};
          ac_n  = ac_q + 1'b1;
        end else begin
          sdo_n = rom_data[dc_q[DIX-1:0]];
          dc_n  = dc_q + 1'b1;
          if (dc_q == DC_LAST) clr = 1'b1;
        end
      end else begin
        sdo_n = STATUS_BYTE[dc_q[SIX-1:0]];
        dc_n  = dc_q + 1'b1;
        if (dc_q == SC_LAST) clr = 1'b1;
      end
      if (clr) begin
        op_n  = '0;
        oc_n  = '0;
        adr_n = '0;
        ac_n  = '0;
        dc_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      oc_q  <= '0;
      adr_q <= '0;
      ac_q  <= '0;
      dc_q  <= '0;
      sdo_q <= 1'b0;
      err_q <= 1'b0;
    end else if (step) begin
      op_q  <= op_n;
      oc_q  <= oc_n;
      adr_q <= adr_n;
      ac_q  <= ac_n;
      dc_q  <= dc_n;
      sdo_q <= sdo_n;
      err_q <= err_n;
    end
  end

  assign rom_addr = adr_q;
  assign sdo      = sdo_q;
  assign err      = err_q;
endmodule

// File: rtl/eeprom_bitbang_resp.sv
module eeprom_bitbang_resp
  import eeb_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int BE_W  = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             err
);
  logic sclk, sdi, req, gnt, step, step_din, wr_full, sdo;
  logic [ADR_W-1:0] rom_addr;
  logic [DAT_W-1:0] rom_data;

  eeb_ctrl_reg #(.REG_W(REG_W), .BE_W(BE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .sclk(sclk), .sdi(sdi), .req(req), .gnt(gnt), .step(step),
    .step_din(step_din), .wr_full(wr_full)
  );

  eeb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .din(step_din),
    .rom_data(rom_data), .rom_addr(rom_addr), .sdo(sdo), .err(err)
  );

  eeb_rom u_rom (.addr(rom_addr), .word(rom_data));

  always_comb begin
    rd_data                    = '0;
    rd_data[B_SCLK]            = sclk;
    rd_data[B_SDI]             = sdi;
    rd_data[B_SDO]             = sdo;
    rd_data[B_REQ]             = req;
    rd_data[B_GNT]             = gnt;
    rd_data[TYPE_LSB+:TYPE_W]  = MEM_TYPE;
  end

  logic unused_full;
  assign unused_full = wr_full;
endmodule

// File: rtl/eeb_checker.sv
module eeb_checker #(
  parameter int REG_W = 32,
  parameter int BE_W  = REG_W / 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [BE_W-1:0]  wr_be,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             err
);
  assert_type_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[9:8] == 2'd1);

  assert_partial_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != '1) |=> ($stable(rd_data) && $stable(err)));

  assert_grant_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '1) |=> (rd_data[4] == $past(wr_data[3])));

  assert_held_clock_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '1 && rd_data[0]) |=> ($stable(rd_data[2]) && $stable(err)));

  assert_idle_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rd_data) && $stable(err)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind eeprom_bitbang_resp eeb_checker #(.REG_W(REG_W), .BE_W(BE_W)) u_chk (.*);

// File: tb/eeprom_bitbang_resp_bench.sv
`timescale 1ns/1ps
module eeprom_bitbang_resp_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] fixw;

  always #2.5 clk = ~clk;

  eeprom_bitbang_resp u_eeprom_bitbang_resp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_data), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int a);
    logic [7:0] b;
    b = 8'(a);
    if (a == 63) return fixw;
    return {b, b ^ 8'hA5};
  endfunction

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; wr_data = '0;
  endtask

  function automatic logic [31:0] rv(input bit sk, input bit di, input bit rq);
    return {28'd0, rq, 1'b0, di, sk};
  endfunction

  task automatic bit_out(input bit b);
    wr(rv(1'b0, b, 1'b1), 4'hF);
    wr(rv(1'b1, b, 1'b1), 4'hF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    send_byte(8'h03);
    send_byte(a);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      bit_out(1'b0);
      w[i] = rd_data[2];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, s;
    logic [31:0] snap;
    fixw = 16'hBABA;
    for (int a = 0; a < 63; a++) fixw = fixw - {8'(a), 8'(a) ^ 8'hA5};
    rst_n = 1'b0; wr_en = 1'b0; wr_be = 4'h0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(rd_data == 32'h0000_0100, "R1 reset rd_data", rd_data, 32'h100);
    chk(err == 1'b0, "R1 reset err", {31'd0, err}, 0);

    // R2: partial writes ignored
    wr(32'hFFFF_FFFF, 4'h7);
    chk(rd_data == 32'h100, "R2 partial be=7", rd_data, 32'h100);
    wr(32'hFFFF_FFFF, 4'h1);
    chk(rd_data == 32'h100, "R2 partial be=1", rd_data, 32'h100);

    // R3: grant mirrors request
    wr(rv(1'b0, 1'b0, 1'b1), 4'hF);
    chk(rd_data[4:3] == 2'b11, "R3 grant set", {30'd0, rd_data[4:3]}, 3);
    wr(rv(1'b0, 1'b0, 1'b0), 4'hF);
    chk(rd_data[4:3] == 2'b00, "R3 grant cleared", {30'd0, rd_data[4:3]}, 0);

    // R5 R6 R10: sweep of every address
    for (int a = 0; a < 256; a++) begin
      read_word(8'(a), w);
      chk(w == exp_word(a), $sformatf("R6 R10 word %0d", a), {16'd0, w}, {16'd0, exp_word(a)});
    end

    // R10: checksum over words 0..63 as read
    s = '0;
    for (int a = 0; a < 64; a++) begin
      read_word(8'(a), w);
      s = s + w;
    end
    chk(s == 16'hBABA, "R10 checksum", {16'd0, s}, 32'hBABA);

    // R4: held-high and clearing writes do not step
    send_byte(8'h03);
    for (int i = 7; i >= 0; i--) begin
      bit_out(8'h5A >> i);
      wr(rv(1'b1, ~((8'h5A >> i) & 1), 1'b1), 4'hF);
      wr(rv(1'b0, 1'b1, 1'b1), 4'hF);
    end
    w = '0;
    for (int i = 0; i < 16; i++) begin
      bit_out(1'b0);
      w[i] = rd_data[2];
      snap = rd_data;
      wr(rv(1'b1, 1'b1, 1'b1), 4'hF);
      if (i == 3) chk(rd_data[2] == snap[2], "R4 held clock keeps dout", {31'd0, rd_data[2]}, {31'd0, snap[2]});
      wr(32'hFFFF_FFF8, 4'hE);
    end
    chk(w == exp_word(8'h5A), "R4 redundant writes", {16'd0, w}, {16'd0, exp_word(8'h5A)});

    // R7 R8: read ending with dout=1, then status back to back
    read_word(8'h80, w);
    chk(rd_data[2] == 1'b1, "R7 precondition dout=1", {31'd0, rd_data[2]}, 1);
    send_byte(8'h05);
    for (int i = 0; i < 8; i++) begin
      bit_out(1'b1);
      chk(rd_data[2] == 1'b0, $sformatf("R7 status bit %0d", i), {31'd0, rd_data[2]}, 0);
    end
    read_word(8'hC3, w);
    chk(w == exp_word(8'hC3), "R8 read after status", {16'd0, w}, {16'd0, exp_word(8'hC3)});
    chk(err == 1'b0, "R9 no error on valid opcodes", {31'd0, err}, 0);

    // R9: unknown opcode
    send_byte(8'h06);
    chk(err == 1'b1, "R9 err set", {31'd0, err}, 1);
    read_word(8'h11, w);
    chk(w == exp_word(8'h11), "R9 idle after bad opcode", {16'd0, w}, {16'd0, exp_word(8'h11)});
    chk(err == 1'b1, "R9 err sticky", {31'd0, err}, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule